// File: doc/BRIEF.md
# Byte Register ALU with Flag Update and Skip Decision

This block is the combinational execute stage for the byte-wide register operations of a small 8-bit accumulator processor. Each cycle it takes a 16-bit instruction word, the working register value, the byte fetched from the register file and the current carry. It returns the 8-bit result, a write strobe for the working register or for the register file, a five-bit flag vector with a matching update mask, and a skip request for the test-and-skip class of operations.

Instruction fields: bits 15..10 (or 15..9 when bits 15..12 are `0110`) hold the operation code. The destination select bit is bit 9 for operations that carry one. Bit 8 is the bank-access bit and bits 7..0 are the register address. Banking and addressing happen elsewhere, so the block ignores bit 8 and the address field. Flag vector order: bit 0 = C, bit 1 = DC, bit 2 = Z, bit 3 = OV, bit 4 = N.

Top module: `bralu_core`

## Requirements
- R1: When bits 15..12 are `0110`, bits 11..9 select one of eight operations with no destination bit: 000 skip-if-less, 001 skip-if-equal, 010 skip-if-greater, 011 test-skip-if-zero, 100 set, 101 clear, 110 negate, 111 move W to f. Otherwise bits 15..10 select the operation from this list: 000001 dec, 000100 OR, 000101 AND, 000110 XOR, 000111 complement, 001000 add-with-carry, 001001 add, 001010 inc, 001011 dec-skip-zero, 001100 rotate-right-through-carry, 001101 rotate-left-through-carry, 001110 nibble swap, 001111 inc-skip-zero, 010000 rotate-right, 010001 rotate-left, 010010 inc-skip-nonzero, 010011 dec-skip-nonzero, 010100 move f, 010101 W-minus-f-with-borrow, 010110 f-minus-W-with-borrow, 010111 f-minus-W. Any other code drives `op_valid` low, both write strobes low, the mask to zero and the skip to zero.
- R2: For operations with a destination bit, bit 9 = 0 raises `wr_w` and bit 9 = 1 raises `wr_f`. Clear, set, negate and move W to f raise only `wr_f`. The compares and test-skip raise neither. Bit 8 and bits 7..0 have no effect on any output.
- R3: Add computes f+W, add-with-carry computes f+W+C, and increment computes f+1. C is the carry out of bit 7, DC is the carry out of bit 3, and OV flags two's-complement overflow.
- R4: f-minus-W, f-minus-W-with-borrow (f-W-!C), W-minus-f-with-borrow (W-f-!C), decrement (f-1) and negate (0-f) use C=1 to mean no borrow. DC means no borrow out of bit 3, and OV flags signed overflow.
- R5: AND, OR, XOR, complement, move f, nibble swap, set (0xFF), clear (0x00) and move W to f (result W) produce their bitwise results.
- R6: Rotate left through carry gives {f[6:0],C} with the new C = f[7]. Rotate right through carry gives {C,f[7:1]} with the new C = f[0]. The plain rotates wrap the end bit around.
- R7: The mask is 11111 for add, add-with-carry, the three subtracts, inc, dec and negate. It is 10100 (Z,N) for AND, OR, XOR, complement, move f and the plain rotates. It is 10101 (C,Z,N) for the carry rotates and 00100 (Z) for clear. It is 00000 for set, swap, move W to f, compares, test-skip and the skip forms of inc and dec.
- R8: Z is set when the result is zero, and N equals result bit 7. Flag bits outside the mask read 0.
- R9: Compares are unsigned f-versus-W tests. They skip when f==W, f>W or f<W respectively, and the result equals f.
- R10: Inc-skip-zero and dec-skip-zero skip when the new value is 0. Inc-skip-nonzero and dec-skip-nonzero skip when it is not 0. Test-skip skips when f is 0 and its result is f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| wreg | input | 8 | Working register value |
| fval | input | 8 | Register-file operand |
| cin | input | 1 | Current carry flag |
| result | output | 8 | Operation result |
| wr_w | output | 1 | Write result to working register |
| wr_f | output | 1 | Write result to register file |
| flags | output | 5 | New flag values {N,OV,Z,DC,C}, masked |
| flag_mask | output | 5 | Which flags to update |
| skip | output | 1 | Skip the next instruction |
| op_valid | output | 1 | Operation code recognised |

## Verification
The arithmetic group is run with operands that sit at the carry edges: a low-nibble carry alone, the 0x7F to 0x80 signed step, and an 0xFF wrap to zero. These separate DC from C, and OV from C. The subtracts are run with each carry-in value, so the borrow polarity and the operand order of the two borrow forms cannot be confused. The compares use 0x80 against 0x7F, which exposes a signed comparison. The skip forms are run on the values that wrap to zero and on values that do not, which shows whether the test reads the value before or after the update. Each case is repeated with bit 8 and the address field changed, and the unused codes around each group are applied as well.

// File: rtl/bralu_pkg.sv
package bralu_pkg;
  localparam int DW     = 8;
  localparam int IW     = 16;
  localparam int NFLAG  = 5;
  localparam int NIB    = 4;
  localparam int FC     = 0;
  localparam int FDC    = 1;
  localparam int FZ     = 2;
  localparam int FOV    = 3;
  localparam int FN     = 4;
  localparam int DBIT   = 9;

  localparam logic [NFLAG-1:0] M_ALL  = 5'b11111;
  localparam logic [NFLAG-1:0] M_ZN   = 5'b10100;
  localparam logic [NFLAG-1:0] M_CZN  = 5'b10101;
  localparam logic [NFLAG-1:0] M_Z    = 5'b00100;
  localparam logic [NFLAG-1:0] M_NONE = 5'b00000;

  typedef enum logic [4:0] {
    OP_BAD, OP_ADD, OP_ADDC, OP_SUBFW, OP_SUBFWB, OP_SUBWFB,
    OP_INC, OP_DEC, OP_NEG, OP_AND, OP_IOR, OP_XOR, OP_COM,
    OP_MOVF, OP_SWAP, OP_RLC, OP_RRC, OP_RLN, OP_RRN, OP_CLR,
    OP_SET, OP_MOVWF, OP_CPEQ, OP_CPGT, OP_CPLT, OP_TST,
    OP_DECSZ, OP_DECSNZ, OP_INCSZ, OP_INCSNZ
  } op_e;

  typedef enum logic [1:0] {DST_NONE, DST_W, DST_F, DST_BY_D} dst_e;

  typedef struct packed {
    op_e              op;
    dst_e             dst;
    logic [NFLAG-1:0] mask;
  } dec_s;

  typedef struct packed {
    logic          c;
    logic          dc;
    logic          ov;
    logic [DW-1:0] r;
  } sum_s;

  // Nibble-split adder: carry out of bit 3 and bit DW-1, signed overflow.
  function automatic sum_s add_bytes(input logic [DW-1:0] a,
                                     input logic [DW-1:0] b,
                                     input logic ci);
    logic [NIB:0]    lo;
    logic [DW-NIB:0] hi;
    sum_s            s;
    lo   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, ci};
    hi   = {1'b0, a[DW-1:NIB]} + {1'b0, b[DW-1:NIB]} + {{(DW-NIB){1'b0}}, lo[NIB]};
    s.r  = {hi[DW-NIB-1:0], lo[NIB-1:0]};
    s.dc = lo[NIB];
    s.c  = hi[DW-NIB];
    s.ov = (a[DW-1] == b[DW-1]) && (s.r[DW-1] != a[DW-1]);
    return s;
  endfunction
endpackage

// File: rtl/bralu_decode.sv
module bralu_decode
  import bralu_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_s          dec
);
  always_comb begin
    dec = '{op: OP_BAD, dst: DST_NONE, mask: M_NONE};
    if (instr[15:12] == 4'b0110) begin
      case (instr[11:9])
        3'b000: dec = '{op: OP_CPLT,  dst: DST_NONE, mask: M_NONE};
        3'b001: dec = '{op: OP_CPEQ,  dst: DST_NONE, mask: M_NONE};
        3'b010: dec = '{op: OP_CPGT,  dst: DST_NONE, mask: M_NONE};
        3'b011: dec = '{op: OP_TST,   dst: DST_NONE, mask: M_NONE};
        3'b100: dec = '{op: OP_SET,   dst: DST_F,    mask: M_NONE};
        3'b101: dec = '{op: OP_CLR,   dst: DST_F,    mask: M_Z};
        3'b110: dec = '{op: OP_NEG,   dst: DST_F,    mask: M_ALL};
        default: dec = '{op: OP_MOVWF, dst: DST_F,   mask: M_NONE};
      endcase
    end else begin
      case (instr[15:10])
        6'b000001: dec = '{op: OP_DEC,    dst: DST_BY_D, mask: M_ALL};
        6'b000100: dec = '{op: OP_IOR,    dst: DST_BY_D, mask: M_ZN};
        6'b000101: dec = '{op: OP_AND,    dst: DST_BY_D, mask: M_ZN};
        6'b000110: dec = '{op: OP_XOR,    dst: DST_BY_D, mask: M_ZN};
        6'b000111: dec = '{op: OP_COM,    dst: DST_BY_D, mask: M_ZN};
        6'b001000: dec = '{op: OP_ADDC,   dst: DST_BY_D, mask: M_ALL};
        6'b001001: dec = '{op: OP_ADD,    dst: DST_BY_D, mask: M_ALL};
        6'b001010: dec = '{op: OP_INC,    dst: DST_BY_D, mask: M_ALL};
        6'b001011: dec = '{op: OP_DECSZ,  dst: DST_BY_D, mask: M_NONE};
        6'b001100: dec = '{op: OP_RRC,    dst: DST_BY_D, mask: M_CZN};
        6'b001101: dec = '{op: OP_RLC,    dst: DST_BY_D, mask: M_CZN};
        6'b001110: dec = '{op: OP_SWAP,   dst: DST_BY_D, mask: M_NONE};
        6'b001111: dec = '{op: OP_INCSZ,  dst: DST_BY_D, mask: M_NONE};
        6'b010000: dec = '{op: OP_RRN,    dst: DST_BY_D, mask: M_ZN};
        6'b010001: dec = '{op: OP_RLN,    dst: DST_BY_D, mask: M_ZN};
        6'b010010: dec = '{op: OP_INCSNZ, dst: DST_BY_D, mask: M_NONE};
        6'b010011: dec = '{op: OP_DECSNZ, dst: DST_BY_D, mask: M_NONE};
        6'b010100: dec = '{op: OP_MOVF,   dst: DST_BY_D, mask: M_ZN};
        6'b010101: dec = '{op: OP_SUBWFB, dst: DST_BY_D, mask: M_ALL};
        6'b010110: dec = '{op: OP_SUBFWB, dst: DST_BY_D, mask: M_ALL};
        6'b010111: dec = '{op: OP_SUBFW,  dst: DST_BY_D, mask: M_ALL};
        default:   dec = '{op: OP_BAD,    dst: DST_NONE, mask: M_NONE};
      endcase
    end
  end
endmodule

// File: rtl/bralu_datapath.sv
module bralu_datapath
  import bralu_pkg::*;
(
  input  op_e              op,
  input  logic [DW-1:0]    wv,
  input  logic [DW-1:0]    fv,
  input  logic             ci,
  output logic [DW-1:0]    res,
  output logic [NFLAG-1:0] raw_flags
);
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] ZERO = '0;
  localparam logic [DW-1:0] ONES = '1;

  sum_s s;
  logic c_rot;

  always_comb begin
    unique case (op)
      OP_ADD:                      s = add_bytes(fv, wv, 1'b0);
      OP_ADDC:                     s = add_bytes(fv, wv, ci);
      OP_SUBFW:                    s = add_bytes(fv, ~wv, 1'b1);
      OP_SUBFWB:                   s = add_bytes(fv, ~wv, ci);
      OP_SUBWFB:                   s = add_bytes(wv, ~fv, ci);
      OP_INC, OP_INCSZ, OP_INCSNZ: s = add_bytes(fv, ONE, 1'b0);
      OP_DEC, OP_DECSZ, OP_DECSNZ: s = add_bytes(fv, ONES, 1'b0);
      OP_NEG:                      s = add_bytes(ZERO, ~fv, 1'b1);
      default:                     s = add_bytes(fv, ZERO, 1'b0);
    endcase
  end

  always_comb begin
    c_rot = s.c;
    unique case (op)
      OP_AND:   res = fv & wv;
      OP_IOR:   res = fv | wv;
      OP_XOR:   res = fv ^ wv;
      OP_COM:   res = ~fv;
      OP_SWAP:  res = {fv[NIB-1:0], fv[DW-1:NIB]};
      OP_RLC:   begin res = {fv[DW-2:0], ci};      c_rot = fv[DW-1]; end
      OP_RRC:   begin res = {ci, fv[DW-1:1]};      c_rot = fv[0];    end
      OP_RLN:   res = {fv[DW-2:0], fv[DW-1]};
      OP_RRN:   res = {fv[0], fv[DW-1:1]};
      OP_CLR:   res = ZERO;
      OP_SET:   res = ONES;
      OP_MOVWF: res = wv;
      OP_MOVF, OP_CPEQ, OP_CPGT, OP_CPLT, OP_TST, OP_BAD: res = fv;
      default:  res = s.r;
    endcase
  end

  always_comb begin
    raw_flags      = '0;
    raw_flags[FC]  = c_rot;
    raw_flags[FDC] = s.dc;
    raw_flags[FOV] = s.ov;
    raw_flags[FZ]  = (res == ZERO);
    raw_flags[FN]  = res[DW-1];
  end
endmodule

// File: rtl/bralu_skip.sv
module bralu_skip
  import bralu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] wv,
  input  logic [DW-1:0] fv,
  input  logic [DW-1:0] res,
  output logic          skip
);
  logic res_zero;
  assign res_zero = (res == '0);

  always_comb begin
    unique case (op)
      OP_CPEQ:             skip = (fv == wv);
      OP_CPGT:             skip = (fv > wv);
      OP_CPLT:             skip = (fv < wv);
      OP_TST:              skip = (fv == '0);
      OP_INCSZ, OP_DECSZ:  skip = res_zero;
      OP_INCSNZ, OP_DECSNZ: skip = !res_zero;
      default:             skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/bralu_core.sv
module bralu_core
  import bralu_pkg::*;
(
  input  logic [IW-1:0]    instr,
  input  logic [DW-1:0]    wreg,
  input  logic [DW-1:0]    fval,
  input  logic             cin,
  output logic [DW-1:0]    result,
  output logic             wr_w,
  output logic             wr_f,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] flag_mask,
  output logic             skip,
  output logic             op_valid
);
  dec_s             dec;
  logic [NFLAG-1:0] raw_flags;
  logic             dbit;

  bralu_decode u_dec (.instr(instr), .dec(dec));

  bralu_datapath u_dp (
    .op(dec.op), .wv(wreg), .fv(fval), .ci(cin),
    .res(result), .raw_flags(raw_flags)
  );

  bralu_skip u_skp (
    .op(dec.op), .wv(wreg), .fv(fval), .res(result), .skip(skip)
  );

  assign dbit      = instr[DBIT];
  assign op_valid  = (dec.op != OP_BAD);
  assign wr_w      = (dec.dst == DST_W) || ((dec.dst == DST_BY_D) && !dbit);
  assign wr_f      = (dec.dst == DST_F) || ((dec.dst == DST_BY_D) && dbit);
  assign flag_mask = dec.mask;
  assign flags     = raw_flags & dec.mask;
endmodule

// File: rtl/bralu_chk.sv
module bralu_chk
  import bralu_pkg::*;
(
  input logic [IW-1:0]    instr,
  input logic [DW-1:0]    wreg,
  input logic [DW-1:0]    fval,
  input logic             cin,
  input logic [DW-1:0]    result,
  input logic             wr_w,
  input logic             wr_f,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] flag_mask,
  input logic             skip,
  input logic             op_valid
);
  logic [DW:0] wide_sum;
  assign wide_sum = {1'b0, fval} + {1'b0, wreg};

  always_comb begin
    AST_ONE_TARGET: assert (!(wr_w && wr_f)) else $error("two targets"); // R2
    AST_BAD_QUIET: assert (op_valid || (!wr_w && !wr_f && flag_mask == '0 && !skip))
      else $error("unknown code not quiet"); // R1
    AST_ZERO_FLAG: assert (!flag_mask[FZ] || (flags[FZ] == (result == '0)))
      else $error("Z mismatch"); // R8
    AST_SIGN_FLAG: assert (!flag_mask[FN] || (flags[FN] == result[DW-1]))
      else $error("N mismatch"); // R8
    AST_SKIP_FLAGLESS: assert (!skip || flag_mask == '0)
      else $error("skip op touched flags"); // R7
    AST_ADD_CARRY: assert (instr[15:10] != 6'b001001 || flags[FC] == wide_sum[DW])
      else $error("add carry"); // R3
    AST_SUB_NOBORROW: assert (instr[15:10] != 6'b010111 || flags[FC] == (fval >= wreg))
      else $error("sub borrow"); // R4
    AST_RLC_SHAPE: assert (instr[15:10] != 6'b001101 || result == {fval[DW-2:0], cin})
      else $error("rotate shape"); // R6
    AST_EQ_SKIP: assert (instr[15:9] != 7'b0110001 || skip == (fval == wreg))
      else $error("equal skip"); // R9
  end
endmodule

bind bralu_core bralu_chk u_chk (
  .instr(instr), .wreg(wreg), .fval(fval), .cin(cin), .result(result),
  .wr_w(wr_w), .wr_f(wr_f), .flags(flags), .flag_mask(flag_mask),
  .skip(skip), .op_valid(op_valid)
);

// File: tb/sim_bralu_core.sv
module sim_bralu_core;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  wreg = '0, fval = '0;
  logic        cin = 1'b0;
  logic [7:0]  result;
  logic        wr_w, wr_f, skip, op_valid;
  logic [4:0]  flags, flag_mask;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  bralu_core u0 (
    .instr(instr), .wreg(wreg), .fval(fval), .cin(cin), .result(result),
    .wr_w(wr_w), .wr_f(wr_f), .flags(flags), .flag_mask(flag_mask),
    .skip(skip), .op_valid(op_valid)
  );

  function automatic logic [15:0] i6(logic [5:0] code, logic d, logic a, logic [7:0] adr);
    return {code, d, a, adr};
  endfunction
  function automatic logic [15:0] i7(logic [2:0] low, logic a, logic [7:0] adr);
    return {4'b0110, low, a, adr};
  endfunction

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Independent model written from the requirements, flags {N,OV,Z,DC,C}.
  task automatic model(input logic [15:0] ins, input int w, input int f, input int c,
                       output logic v, output int r, output logic ww, output logic wf,
                       output logic [4:0] fl, output logic [4:0] mk, output logic sk);
    int s, so, bor; logic cf, dcf, arith, byd, tof;
    v = 1; r = f; ww = 0; wf = 0; fl = 0; mk = 0; sk = 0;
    s = 0; so = 0; cf = 0; dcf = 0; arith = 0; byd = 1; tof = 0; bor = 1 - c;
    if (ins[15:12] == 4'b0110) begin
      byd = 0;
      case (ins[11:9])
        3'b000: sk = (f < w);
        3'b001: sk = (f == w);
        3'b010: sk = (f > w);
        3'b011: sk = (f == 0);
        3'b100: begin r = 255; tof = 1; end
        3'b101: begin r = 0; tof = 1; mk = 5'b00100; end
        3'b110: begin s = -f; cf = (f == 0); dcf = (f % 16 == 0); so = -sgn(f);
                      arith = 1; tof = 1; mk = 5'b11111; end
        default: begin r = w; tof = 1; end
      endcase
    end else begin
      case (ins[15:10])
        6'b001001: begin s = f + w; cf = s > 255; dcf = (f%16 + w%16) > 15;
                         so = sgn(f) + sgn(w); arith = 1; mk = 5'b11111; end
        6'b001000: begin s = f + w + c; cf = s > 255; dcf = (f%16 + w%16 + c) > 15;
                         so = sgn(f) + sgn(w) + c; arith = 1; mk = 5'b11111; end
        6'b010111: begin s = f - w; cf = f >= w; dcf = (f%16) >= (w%16);
                         so = sgn(f) - sgn(w); arith = 1; mk = 5'b11111; end
        6'b010110: begin s = f - w - bor; cf = f >= w + bor; dcf = (f%16) >= (w%16) + bor;
                         so = sgn(f) - sgn(w) - bor; arith = 1; mk = 5'b11111; end
        6'b010101: begin s = w - f - bor; cf = w >= f + bor; dcf = (w%16) >= (f%16) + bor;
                         so = sgn(w) - sgn(f) - bor; arith = 1; mk = 5'b11111; end
        6'b001010, 6'b001111, 6'b010010: begin
                         s = f + 1; cf = f == 255; dcf = f % 16 == 15; so = sgn(f) + 1; arith = 1;
                         if (ins[15:10] == 6'b001010) mk = 5'b11111; end
        6'b000001, 6'b001011, 6'b010011: begin
                         s = f - 1; cf = f >= 1; dcf = f % 16 >= 1; so = sgn(f) - 1; arith = 1;
                         if (ins[15:10] == 6'b000001) mk = 5'b11111; end
        6'b000101: begin r = f & w; mk = 5'b10100; end
        6'b000100: begin r = f | w; mk = 5'b10100; end
        6'b000110: begin r = f ^ w; mk = 5'b10100; end
        6'b000111: begin r = 255 - f; mk = 5'b10100; end
        6'b010100: mk = 5'b10100;
        6'b001110: r = (f % 16) * 16 + f / 16;
        6'b001101: begin r = (f * 2) % 256 + c; cf = f >= 128; mk = 5'b10101; end
        6'b001100: begin r = f / 2 + c * 128; cf = f % 2; mk = 5'b10101; end
        6'b010001: begin r = (f * 2) % 256 + f / 128; mk = 5'b10100; end
        6'b010000: begin r = f / 2 + (f % 2) * 128; mk = 5'b10100; end
        default: begin v = 0; byd = 0; end
      endcase
    end
    if (arith) r = ((s % 256) + 256) % 256;
    case (ins[15:10])
      6'b001011, 6'b001111: sk = (r == 0);
      6'b010011, 6'b010010: sk = (r != 0);
      default: ;
    endcase
    fl[0] = cf; fl[1] = dcf; fl[2] = (r == 0); fl[3] = (so > 127 || so < -128); fl[4] = (r >= 128);
    fl = fl & mk;
    if (byd) begin ww = !ins[9]; wf = ins[9]; end
    else if (tof) wf = 1;
  endtask

  task automatic apply(input string tag, input logic [15:0] ins, input int w, input int f, input int c);
    logic v, ww, wf, sk; int r; logic [4:0] fl, mk;
    @(negedge clk);
    instr = ins; wreg = 8'(w); fval = 8'(f); cin = 1'(c);
    #(PERIOD/4);
    model(ins, w, f, c, v, r, ww, wf, fl, mk, sk);
    checks++;
    if (op_valid !== v || wr_w !== ww || wr_f !== wf || flags !== fl ||
        flag_mask !== mk || skip !== sk || (v && result !== 8'(r))) begin
      errors++;
      $display("FAIL %s instr=%h: got res=%h ww=%b wf=%b fl=%b mk=%b sk=%b v=%b exp res=%h ww=%b wf=%b fl=%b mk=%b sk=%b v=%b",
               tag, ins, result, wr_w, wr_f, flags, flag_mask, skip, op_valid,
               8'(r), ww, wf, fl, mk, sk, v);
    end
  endtask

  task automatic t_reset;
    checks++;
    #(PERIOD/4);
    if (op_valid !== 1'b0 || wr_w !== 1'b0 || wr_f !== 1'b0 || flag_mask !== 5'b0 || skip !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset-state: v=%b ww=%b wf=%b mk=%b sk=%b exp all zero",
               op_valid, wr_w, wr_f, flag_mask, skip);
    end
  endtask

  task automatic t_add;
    apply("R3 R7 R8 add nibble carry", i6(6'b001001, 1, 0, 8'h20), 8'h01, 8'h0F, 0);
    apply("R3 add signed overflow",    i6(6'b001001, 1, 0, 8'h20), 8'h01, 8'h7F, 0);
    apply("R3 add wrap zero",          i6(6'b001001, 0, 0, 8'h20), 8'h01, 8'hFF, 0);
    apply("R3 addc carry in",          i6(6'b001000, 1, 0, 8'h21), 8'h20, 8'h10, 1);
    apply("R3 addc carry out",         i6(6'b001000, 1, 0, 8'h21), 8'h80, 8'h7F, 1);
    apply("R3 inc wrap",               i6(6'b001010, 1, 0, 8'h05), 8'h00, 8'hFF, 0);
    apply("R3 inc overflow",           i6(6'b001010, 0, 0, 8'h05), 8'h00, 8'h7F, 1);
  endtask

  task automatic t_sub;
    apply("R4 sub no borrow",   i6(6'b010111, 1, 0, 8'h30), 8'h03, 8'h05, 0);
    apply("R4 sub borrow",      i6(6'b010111, 1, 0, 8'h30), 8'h05, 8'h03, 0);
    apply("R4 sub overflow",    i6(6'b010111, 1, 0, 8'h30), 8'h01, 8'h80, 1);
    apply("R4 subfwb c0",       i6(6'b010110, 1, 0, 8'h31), 8'h05, 8'h05, 0);
    apply("R4 subfwb c1",       i6(6'b010110, 1, 0, 8'h31), 8'h05, 8'h05, 1);
    apply("R4 subwfb order",    i6(6'b010101, 0, 0, 8'h32), 8'h10, 8'h01, 1);
    apply("R4 subwfb borrow",   i6(6'b010101, 0, 0, 8'h32), 8'h10, 8'h01, 0);
    apply("R4 dec zero",        i6(6'b000001, 1, 0, 8'h33), 8'h00, 8'h00, 1);
    apply("R4 dec overflow",    i6(6'b000001, 1, 0, 8'h33), 8'h00, 8'h80, 0);
    apply("R4 neg zero",        i7(3'b110, 0, 8'h34), 8'h00, 8'h00, 0);
    apply("R4 neg min",         i7(3'b110, 0, 8'h34), 8'h00, 8'h80, 0);
    apply("R4 neg one",         i7(3'b110, 0, 8'h34), 8'h00, 8'h01, 1);
  endtask

  task automatic t_logic;
    apply("R5 and",   i6(6'b000101, 1, 0, 8'h40), 8'hF0, 8'h3C, 0);
    apply("R5 ior",   i6(6'b000100, 1, 0, 8'h40), 8'h00, 8'h00, 1);
    apply("R5 xor",   i6(6'b000110, 0, 0, 8'h40), 8'hAA, 8'h55, 0);
    apply("R5 com",   i6(6'b000111, 1, 0, 8'h40), 8'h00, 8'hFF, 0);
    apply("R5 movf",  i6(6'b010100, 0, 0, 8'h40), 8'h12, 8'h80, 0);
    apply("R5 swap",  i6(6'b001110, 1, 0, 8'h40), 8'h00, 8'hA5, 1);
    apply("R5 set",   i7(3'b100, 0, 8'h41), 8'h00, 8'h12, 0);
    apply("R5 clear", i7(3'b101, 0, 8'h41), 8'h00, 8'h12, 1);
    apply("R5 movwf", i7(3'b111, 0, 8'h41), 8'h9C, 8'h12, 0);
  endtask

  task automatic t_rotate;
    apply("R6 rlc",      i6(6'b001101, 1, 0, 8'h50), 8'h00, 8'h80, 1);
    apply("R6 rlc zero", i6(6'b001101, 1, 0, 8'h50), 8'h00, 8'h80, 0);
    apply("R6 rrc",      i6(6'b001100, 1, 0, 8'h50), 8'h00, 8'h01, 0);
    apply("R6 rrc cin",  i6(6'b001100, 0, 0, 8'h50), 8'h00, 8'h02, 1);
    apply("R6 rln",      i6(6'b010001, 1, 0, 8'h50), 8'h00, 8'h81, 0);
    apply("R6 rrn",      i6(6'b010000, 1, 0, 8'h50), 8'h00, 8'h01, 1);
  endtask

  task automatic t_dest;
    apply("R2 add to W",          i6(6'b001001, 0, 0, 8'h10), 8'h11, 8'h22, 0);
    apply("R2 add to f",          i6(6'b001001, 1, 0, 8'h10), 8'h11, 8'h22, 0);
    apply("R2 a bit ignored",     i6(6'b001001, 1, 1, 8'hEF), 8'h11, 8'h22, 0);
    apply("R2 a bit on xor",      i6(6'b000110, 0, 1, 8'h00), 8'hAA, 8'h55, 0);
    apply("R2 a bit on clear",    i7(3'b101, 1, 8'hFF), 8'h00, 8'h12, 1);
    apply("R2 compare no target", i7(3'b001, 1, 8'h77), 8'h12, 8'h12, 0);
  endtask

  task automatic t_cmp;
    apply("R9 eq true",        i7(3'b001, 0, 8'h60), 8'h44, 8'h44, 0);
    apply("R9 eq false",       i7(3'b001, 0, 8'h60), 8'h44, 8'h45, 1);
    apply("R9 gt unsigned",    i7(3'b010, 0, 8'h60), 8'h7F, 8'h80, 0);
    apply("R9 gt equal",       i7(3'b010, 0, 8'h60), 8'h80, 8'h80, 0);
    apply("R9 lt unsigned",    i7(3'b000, 0, 8'h60), 8'h7F, 8'h80, 0);
    apply("R9 lt true",        i7(3'b000, 0, 8'h60), 8'h80, 8'h7F, 0);
  endtask

  task automatic t_skipvar;
    apply("R10 tst zero",       i7(3'b011, 0, 8'h70), 8'h00, 8'h00, 0);
    apply("R10 tst nonzero",    i7(3'b011, 0, 8'h70), 8'h00, 8'h01, 0);
    apply("R10 decsz hit",      i6(6'b001011, 1, 0, 8'h70), 8'h00, 8'h01, 0);
    apply("R10 decsz miss",     i6(6'b001011, 0, 0, 8'h70), 8'h00, 8'h00, 1);
    apply("R10 decsnz",         i6(6'b010011, 1, 0, 8'h70), 8'h00, 8'h01, 0);
    apply("R10 incsz hit",      i6(6'b001111, 1, 0, 8'h70), 8'h00, 8'hFF, 0);
    apply("R10 incsnz miss",    i6(6'b010010, 0, 0, 8'h70), 8'h00, 8'hFF, 0);
    apply("R10 incsnz hit",     i6(6'b010010, 1, 0, 8'h70), 8'h00, 8'h10, 0);
  endtask

  task automatic t_bad;
    apply("R1 code 000000", i6(6'b000000, 1, 0, 8'h00), 8'h01, 8'h02, 1);
    apply("R1 code 000010", i6(6'b000010, 1, 0, 8'h00), 8'h01, 8'h02, 0);
    apply("R1 code 011100", i6(6'b011100, 1, 1, 8'h00), 8'h01, 8'h02, 0);
    apply("R1 code 100101", i6(6'b100101, 0, 0, 8'h00), 8'h00, 8'h00, 0);
    apply("R1 code 111111", i6(6'b111111, 1, 1, 8'hFF), 8'h01, 8'h01, 1);
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_logic();
    t_rotate();
    t_dest();
    t_cmp();
    t_skipvar();
    t_bad();
    done = 1;
  end

  initial begin
    for (int k = 0; k < WATCHDOG_CYCLES && !done; k++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, exp completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule